// File: doc/BRIEF.md
# Transmit Descriptor Ring Pointer Manager

This block tracks one transmit descriptor ring held in host memory. Software sets up the ring through a small 32-bit register port: a 64-bit base address split over two words, the ring size in bytes, a starting head index and a tail index. Each descriptor takes 16 bytes. Once the ring is enabled, the block asks a DMA read port for the descriptor at the head index, waits for that descriptor's completion pulse and, if write-back is switched on, first has the completed descriptor written back to the same address. Only then does it step the head index forward.

The head index wraps to zero at the end of the ring. Work stops when head meets tail, which marks the ring as empty. Software hands new work to the block by moving tail forward. Ring geometry (base, length, head) is frozen while the ring is enabled or while a descriptor is in flight. A length that is not a whole number of 128-byte units is refused and raises an error flag.

Top module: `txring_ptr_mgr`

## Requirements
- R1: After reset every register reads zero, `ring_empty` is 1, `len_err` is 0, and neither `dma_req` nor `wb_req` is asserted.
- R2: The base address is written as a low word at offset 0 and a high word at offset 1. Bits [3:0] of the low word are discarded and read back as zero.
- R3: A write to the length register (offset 2) is accepted only if the value is nonzero, a multiple of 128 and no larger than 1048448 bytes (65528 descriptors). A refused value leaves the old length in place and sets `len_err` (also control bit 2). An accepted value clears `len_err`.
- R4: Control register offset 5 has bit 0 = enable and bit 1 = write-back enable. Enable sets only while the stored length is valid and `len_err` is 0. Writes to base, length and head (offset 3) are ignored while the ring is enabled or while a descriptor is in flight.
- R5: The fetch address on `dma_addr` equals base + head*16. `dma_req` and `dma_addr` stay unchanged until `dma_ack`.
- R6: `ring_empty` is 1 exactly when head equals tail. No fetch starts while the ring is empty or disabled.
- R7: With write-back off, head steps by one on the `dma_done` pulse. With write-back on, `wb_req` is raised at the same address after `dma_done`, and head steps only on `wb_ack`.
- R8: When (head+1)*16 equals the ring length, the next step sets head to 0.
- R9: A tail write (offset 4) is accepted at any time and takes effect on the following cycle: `ring_empty` drops one cycle after the write, and `dma_req` rises one cycle after that.
- R10: Descriptors are processed one at a time from the starting head until head equals tail. After that, no further request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dma_req | output | 1 | Descriptor fetch request |
| dma_addr | output | 64 | Descriptor fetch address |
| dma_ack | input | 1 | Fetch request accepted |
| dma_done | input | 1 | Descriptor completion pulse |
| wb_req | output | 1 | Completed-descriptor write-back request |
| wb_addr | output | 64 | Write-back address |
| wb_ack | input | 1 | Write-back accepted |
| ring_empty | output | 1 | Head equals tail |
| len_err | output | 1 | Last length write was refused |

## Verification
The assertions assume that the DMA side behaves well. `dma_ack` arrives only while `dma_req` is high, `dma_done` pulses only after the fetch is accepted, and `wb_ack` arrives only while `wb_req` is high. They also assume that the head value software loads lies inside the ring. The stimulus keeps to these assumptions: it drives each acknowledge for one cycle only after it has seen the matching request, and it sends the completion pulse only after the acknowledge. Every programmed head and tail is below the ring's descriptor count, and tail is moved only to positions that do not split work already handed over.

// File: rtl/txring_pkg.sv
package txring_pkg;
  localparam int ADDR_W           = 64;
  localparam int DATA_W           = 32;
  localparam int RADDR_W          = 3;
  localparam int IDX_W            = 16;
  localparam int LEN_W            = 20;
  localparam int DESC_SHIFT       = 4;
  localparam int LEN_QUANTUM_LOG2 = 7;
  localparam int MAX_DESC         = 65536 - 8;
  localparam logic [DATA_W-1:0] MAX_LEN_BYTES = DATA_W'(MAX_DESC) << DESC_SHIFT;

  localparam logic [RADDR_W-1:0] OFS_BASE_LO = 3'd0;
  localparam logic [RADDR_W-1:0] OFS_BASE_HI = 3'd1;
  localparam logic [RADDR_W-1:0] OFS_LENGTH  = 3'd2;
  localparam logic [RADDR_W-1:0] OFS_HEAD    = 3'd3;
  localparam logic [RADDR_W-1:0] OFS_TAIL    = 3'd4;
  localparam logic [RADDR_W-1:0] OFS_CTRL    = 3'd5;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_FETCH = 2'd1,
    ENG_BUSY  = 2'd2,
    ENG_WB    = 2'd3
  } eng_state_e;

  // A ring length is usable when nonzero, 128-byte granular and in range.
  function automatic logic len_ok(input logic [DATA_W-1:0] bytes);
    return (bytes != '0) &&
           (bytes[LEN_QUANTUM_LOG2-1:0] == '0) &&
           (bytes <= MAX_LEN_BYTES);
  endfunction

  // Index following idx, folded back to zero at the end of the ring.
  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] idx,
                                                 input logic [LEN_W-1:0] bytes);
    logic [LEN_W:0] end_off;
    end_off = (LEN_W+1)'(idx);
    end_off = (end_off + (LEN_W+1)'(1)) << DESC_SHIFT;
    if (end_off >= {1'b0, bytes}) return '0;
    return idx + IDX_W'(1);
  endfunction

  // Byte address of the descriptor slot at idx.
  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
    return base + (ADDR_W'(idx) << DESC_SHIFT);
  endfunction
endpackage

// File: rtl/txring_regs.sv
module txring_regs
  import txring_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [RADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               eng_idle_i,
  input  logic [IDX_W-1:0]   head_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [ADDR_W-1:0]  base_o,
  output logic [LEN_W-1:0]   len_o,
  output logic [IDX_W-1:0]   tail_o,
  output logic               en_o,
  output logic               wb_en_o,
  output logic               len_err_o,
  output logic               head_ld_o,
  output logic [IDX_W-1:0]   head_ld_val_o
);
  localparam int BASE_KEEP = ADDR_W - DESC_SHIFT;

  logic [BASE_KEEP-1:0] base_q;
  logic [LEN_W-1:0]     len_q;
  logic [IDX_W-1:0]     tail_q;
  logic                 en_q;
  logic                 wb_en_q;
  logic                 err_q;
  logic                 geom_locked;
  logic                 wr_base_lo, wr_base_hi, wr_len, wr_tail, wr_ctrl;
  logic                 len_valid_now;

  assign geom_locked   = en_q || !eng_idle_i;
  assign wr_base_lo    = we_i && (addr_i == OFS_BASE_LO) && !geom_locked;
  assign wr_base_hi    = we_i && (addr_i == OFS_BASE_HI) && !geom_locked;
  assign wr_len        = we_i && (addr_i == OFS_LENGTH)  && !geom_locked;
  assign wr_tail       = we_i && (addr_i == OFS_TAIL);
  assign wr_ctrl       = we_i && (addr_i == OFS_CTRL);
  assign len_valid_now = len_ok(DATA_W'(len_q)) && !err_q;

  assign head_ld_o     = we_i && (addr_i == OFS_HEAD) && !geom_locked;
  assign head_ld_val_o = wdata_i[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      len_q   <= '0;
      tail_q  <= '0;
      en_q    <= 1'b0;
      wb_en_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (wr_base_lo) base_q[DATA_W-DESC_SHIFT-1:0] <= wdata_i[DATA_W-1:DESC_SHIFT];
      if (wr_base_hi) base_q[BASE_KEEP-1:DATA_W-DESC_SHIFT] <= wdata_i;
      if (wr_len) begin
        if (len_ok(wdata_i)) begin
          len_q <= wdata_i[LEN_W-1:0];
          err_q <= 1'b0;
        end else begin
          err_q <= 1'b1;
        end
      end
      if (wr_tail) tail_q <= wdata_i[IDX_W-1:0];
      if (wr_ctrl) begin
        en_q <= wdata_i[0] && len_valid_now;
        if (eng_idle_i) wb_en_q <= wdata_i[1];
      end
    end
  end

  assign base_o    = {base_q, {DESC_SHIFT{1'b0}}};
  assign len_o     = len_q;
  assign tail_o    = tail_q;
  assign en_o      = en_q;
  assign wb_en_o   = wb_en_q;
  assign len_err_o = err_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_BASE_LO: rdata_o = base_o[DATA_W-1:0];
      OFS_BASE_HI: rdata_o = base_o[ADDR_W-1:DATA_W];
      OFS_LENGTH:  rdata_o = DATA_W'(len_q);
      OFS_HEAD:    rdata_o = DATA_W'(head_i);
      OFS_TAIL:    rdata_o = DATA_W'(tail_q);
      OFS_CTRL:    rdata_o = DATA_W'({err_q, wb_en_q, en_q});
      default:     rdata_o = '0;
    endcase
  end

  // R4: an enabled ring always carries a usable length
  assert_en_needs_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> len_ok(DATA_W'(len_q)));
  // R4: geometry frozen while enabled
  assert_len_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(len_q) && $stable(base_q));
  // R9: tail write visible on the next cycle
  assert_tail_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == OFS_TAIL) |=> tail_q == $past(wdata_i[IDX_W-1:0]));
  // R3: a refused length leaves the stored value untouched
  assert_bad_len_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_len && !len_ok(wdata_i)) |=> err_q && $stable(len_q));
endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              wb_en_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [IDX_W-1:0]  tail_i,
  input  logic              head_ld_i,
  input  logic [IDX_W-1:0]  head_ld_val_i,
  input  logic              dma_ack_i,
  input  logic              dma_done_i,
  input  logic              wb_ack_i,
  output logic              dma_req_o,
  output logic [ADDR_W-1:0] dma_addr_o,
  output logic              wb_req_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [IDX_W-1:0]  head_o,
  output logic              empty_o,
  output logic              idle_o
);
  eng_state_e         state_q;
  logic [IDX_W-1:0]   head_q;
  logic               start_ev;
  logic               adv_ev;
  logic [ADDR_W-1:0]  cur_addr;

  assign empty_o  = (head_q == tail_i);
  assign start_ev = (state_q == ENG_IDLE) && en_i && !empty_o;
  assign adv_ev   = ((state_q == ENG_BUSY) && dma_done_i && !wb_en_i) ||
                    ((state_q == ENG_WB) && wb_ack_i);
  assign cur_addr = slot_addr(base_i, head_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      head_q  <= '0;
    end else begin
      case (state_q)
        ENG_IDLE:  if (start_ev)   state_q <= ENG_FETCH;
        ENG_FETCH: if (dma_ack_i)  state_q <= ENG_BUSY;
        ENG_BUSY:  if (dma_done_i) state_q <= wb_en_i ? ENG_WB : ENG_IDLE;
        ENG_WB:    if (wb_ack_i)   state_q <= ENG_IDLE;
        default:                   state_q <= ENG_IDLE;
      endcase
      if (head_ld_i)   head_q <= head_ld_val_i;
      else if (adv_ev) head_q <= next_idx(head_q, len_i);
    end
  end

  assign dma_req_o  = (state_q == ENG_FETCH);
  assign dma_addr_o = cur_addr;
  assign wb_req_o   = (state_q == ENG_WB);
  assign wb_addr_o  = cur_addr;
  assign head_o     = head_q;
  assign idle_o     = (state_q == ENG_IDLE);

  // R6: a fetch only starts from a non-empty, enabled ring
  assert_fetch_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req_o) |-> $past(en_i && (head_q != tail_i)));
  // R6: a disabled idle engine stays idle
  assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && state_q == ENG_IDLE) |=> !dma_req_o);
  // R5: request and address held until accepted
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_o && !dma_ack_i) |=> dma_req_o && $stable(dma_addr_o));
  // R7: head moves only on a completion step or a software load
  assert_head_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!head_ld_i && !adv_ev) |=> $stable(head_q));
  // R7: with write-back on, head steps only on the write-back acknowledge
  assert_wb_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ev && wb_en_i) |-> (wb_req_o && wb_ack_i));
  // R7: write-back only requested when enabled
  assert_wb_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req_o |-> wb_en_i);
  // R8: stepping off the last slot lands on zero
  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ev && !head_ld_i && ((32'(head_q) + 32'd1) * 32'd16 == 32'(len_i)))
      |=> head_q == '0);
endmodule

// File: rtl/txring_ptr_mgr.sv
module txring_ptr_mgr
  import txring_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               dma_req,
  output logic [ADDR_W-1:0]  dma_addr,
  input  logic               dma_ack,
  input  logic               dma_done,
  output logic               wb_req,
  output logic [ADDR_W-1:0]  wb_addr,
  input  logic               wb_ack,
  output logic               ring_empty,
  output logic               len_err
);
  logic [ADDR_W-1:0] base_w;
  logic [LEN_W-1:0]  len_w;
  logic [IDX_W-1:0]  tail_w;
  logic [IDX_W-1:0]  head_w;
  logic [IDX_W-1:0]  head_ld_val_w;
  logic              en_w, wb_en_w, head_ld_w, idle_w;

  txring_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .we_i         (reg_we),
    .addr_i       (reg_addr),
    .wdata_i      (reg_wdata),
    .eng_idle_i   (idle_w),
    .head_i       (head_w),
    .rdata_o      (reg_rdata),
    .base_o       (base_w),
    .len_o        (len_w),
    .tail_o       (tail_w),
    .en_o         (en_w),
    .wb_en_o      (wb_en_w),
    .len_err_o    (len_err),
    .head_ld_o    (head_ld_w),
    .head_ld_val_o(head_ld_val_w)
  );

  txring_engine u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_w),
    .wb_en_i      (wb_en_w),
    .base_i       (base_w),
    .len_i        (len_w),
    .tail_i       (tail_w),
    .head_ld_i    (head_ld_w),
    .head_ld_val_i(head_ld_val_w),
    .dma_ack_i    (dma_ack),
    .dma_done_i   (dma_done),
    .wb_ack_i     (wb_ack),
    .dma_req_o    (dma_req),
    .dma_addr_o   (dma_addr),
    .wb_req_o     (wb_req),
    .wb_addr_o    (wb_addr),
    .head_o       (head_w),
    .empty_o      (ring_empty),
    .idle_o       (idle_w)
  );
endmodule

// File: tb/txring_ptr_mgr_tb.sv
`timescale 1ns/1ps
module txring_ptr_mgr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dma_req, wb_req, ring_empty, len_err;
  logic [63:0] dma_addr, wb_addr;
  logic        dma_ack = 1'b0, dma_done = 1'b0, wb_ack = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  txring_ptr_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
    .dma_addr(dma_addr), .dma_ack(dma_ack), .dma_done(dma_done),
    .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
    .ring_empty(ring_empty), .len_err(len_err)
  );

  // {wb, base_hi, base_lo, length, head0, tail}
  localparam logic [128:0] VEC [0:3] = '{
    {1'b0, 32'h0000_0001, 32'h2000_0008, 32'd256, 16'd2,  16'd6},
    {1'b1, 32'h0000_0000, 32'hABCD_123F, 32'd128, 16'd6,  16'd2},
    {1'b0, 32'hFFFF_0000, 32'h0000_0100, 32'd384, 16'd23, 16'd1},
    {1'b1, 32'h0000_0002, 32'h0000_0000, 32'd128, 16'd3,  16'd3}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [15:0] model_next(input logic [15:0] h, input logic [31:0] len);
    return (32'(h) == (len / 32'd16) - 32'd1) ? 16'd0 : h + 16'd1;
  endfunction

  // Service one descriptor; called at a negedge.
  task automatic serve(input logic [63:0] exp_addr, input bit wb, input string tag);
    int spin = 0;
    while (!dma_req && spin < 50) begin @(negedge clk); spin++; end
    chk({tag, " R5 fetch addr"}, dma_addr, exp_addr);
    dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
    dma_done = 1'b1;
    @(negedge clk);
    dma_done = 1'b0;
    if (wb) begin
      chk({tag, " R7 wb_req"}, 64'(wb_req), 64'd1);
      chk({tag, " R7 wb addr"}, wb_addr, exp_addr);
      wb_ack = 1'b1;
      @(negedge clk);
      wb_ack = 1'b0;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), r);
      chk("R1 reg reset", 64'(r), 64'd0);
    end
    chk("R1 ring_empty", 64'(ring_empty), 64'd1);
    chk("R1 len_err", 64'(len_err), 64'd0);
    chk("R1 dma_req", 64'(dma_req), 64'd0);
    chk("R1 wb_req", 64'(wb_req), 64'd0);

    // R4 enable refused with zero length
    wr(3'd5, 32'd1);
    rd(3'd5, r);
    chk("R4 enable blocked len0", 64'(r[0]), 64'd0);

    // R2 low address bits dropped
    wr(3'd0, 32'hABCD_123F);
    rd(3'd0, r);
    chk("R2 base lo", 64'(r), 64'hABCD_1230);
    wr(3'd1, 32'h1234_5678);
    rd(3'd1, r);
    chk("R2 base hi", 64'(r), 64'h1234_5678);

    // R3 length acceptance
    wr(3'd2, 32'd256);
    rd(3'd2, r);
    chk("R3 len ok", 64'(r), 64'd256);
    wr(3'd2, 32'd200);
    rd(3'd2, r);
    chk("R3 bad len kept old", 64'(r), 64'd256);
    chk("R3 len_err set", 64'(len_err), 64'd1);
    rd(3'd5, r);
    chk("R3 ctrl err bit", 64'(r[2]), 64'd1);
    wr(3'd5, 32'd1);
    rd(3'd5, r);
    chk("R4 enable blocked by err", 64'(r[0]), 64'd0);
    wr(3'd2, 32'd1048576);
    chk("R3 oversize refused", 64'(len_err), 64'd1);
    wr(3'd2, 32'd1048448);
    chk("R3 max len clears err", 64'(len_err), 64'd0);
    rd(3'd2, r);
    chk("R3 max len stored", 64'(r), 64'd1048448);
    wr(3'd2, 32'd256);

    // R4 frozen geometry, R9 tail timing
    wr(3'd3, 32'd5);
    wr(3'd4, 32'd5);
    wr(3'd5, 32'd1);
    rd(3'd5, r);
    chk("R4 enabled", 64'(r[0]), 64'd1);
    wr(3'd3, 32'd9);
    rd(3'd3, r);
    chk("R4 head write ignored", 64'(r), 64'd5);
    wr(3'd2, 32'd512);
    rd(3'd2, r);
    chk("R4 len write ignored", 64'(r), 64'd256);
    wr(3'd0, 32'h0);
    rd(3'd0, r);
    chk("R4 base write ignored", 64'(r), 64'hABCD_1230);
    chk("R6 empty when head=tail", 64'(ring_empty), 64'd1);
    chk("R6 no fetch when empty", 64'(dma_req), 64'd0);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'd6;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R9 empty drops next cycle", 64'(ring_empty), 64'd0);
    chk("R9 no req yet", 64'(dma_req), 64'd0);
    @(negedge clk);
    chk("R9 req one cycle later", 64'(dma_req), 64'd1);
    serve(64'h1234_5678_ABCD_1230 + 64'd80, 1'b0, "R9");
    rd(3'd3, r);
    chk("R7 head stepped", 64'(r), 64'd6);
    chk("R10 empty after catch-up", 64'(ring_empty), 64'd1);
    wr(3'd5, 32'd0);

    // Table walk: R5 R7 R8 R10
    for (int v = 0; v < 4; v++) begin
      logic [128:0] e;
      logic [63:0]  base;
      logic [15:0]  h;
      int guard;
      e = VEC[v];
      base = {e[127:96], e[95:68], 4'b0};
      wr(3'd5, 32'd0);
      wr(3'd0, e[95:64]);
      wr(3'd1, e[127:96]);
      wr(3'd2, e[63:32]);
      wr(3'd3, 32'(e[31:16]));
      wr(3'd4, 32'(e[15:0]));
      wr(3'd5, {30'd0, e[128], 1'b1});
      h = e[31:16];
      guard = 0;
      while (h != e[15:0] && guard < 64) begin
        logic [15:0] hn;
        serve(base + (64'(h) << 4), e[128], $sformatf("vec%0d", v));
        hn = model_next(h, e[63:32]);
        rd(3'd3, r);
        chk((hn == 16'd0) ? "R8 wrap head" : "R7 head step", 64'(r), 64'(hn));
        h = hn;
        guard++;
      end
      chk("R10 empty at end", 64'(ring_empty), 64'd1);
      repeat (5) @(negedge clk);
      chk("R10 no further req", 64'(dma_req), 64'd0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule